// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block settles read-after-write hazards for the two source operands of a five-stage 32-bit RISC pipeline whose bypass sits in the decode stage. It takes the two 5-bit source register indices of the instruction being decoded. It compares each one with the destination index and register-write enable of the three later stages: execute, memory and write-back. For each operand it produces a 2-bit select code and the operand value that the code chooses, either one of three bypass values or the register-file read data.

It also adjusts operands for coprocessor-0 move instructions. The rs field of those instructions carries opcode bits, so when no bypass applies the rs operand is replaced by zero. For a move-from, the rt operand carries the coprocessor-0 read data in place of the register-file value. The whole block is combinational. Its outputs follow its inputs within the same cycle, ahead of the decode-to-execute pipeline register.

Top module: `fwd_decode_bypass`

## Requirements
- R1: Select code 0 (binary 00) means the register-file value. It is produced, and the register-file data passed through, when no later stage matches the operand index.
- R2: An execute-stage match gives select code 1 (binary 01), and the operand equals the execute result.
- R3: A memory-stage match gives select code 2 (binary 10), and the operand equals the memory-stage writeback data.
- R4: A write-back-stage match gives select code 3 (binary 11), and the operand equals the write-back data.
- R5: A stage whose destination index equals the operand index but whose write enable is low is not a bypass candidate.
- R6: A destination index of zero never produces a bypass, even with its write enable set, because register 0 always reads as zero.
- R7: When several stages match, execute wins over memory, which wins over write-back.
- R8: The rs and rt selections are made independently of each other.
- R9: With select code 0 on rs and a coprocessor-0 move-to or move-from asserted, the rs operand is zero.
- R10: With select code 0 on rt and a coprocessor-0 move-from asserted, the rt operand is the coprocessor-0 read data. A move-to alone leaves rt as the register-file value.
- R11: A nonzero select code overrides the coprocessor-0 adjustments, so the bypass value is driven.
- R12: `src_fields_i` carries instruction bits [25:16]. The rs index is `src_fields_i[9:5]` (instruction bits [25:21]) and the rt index is `src_fields_i[4:0]` (instruction bits [20:16]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_fields_i | input | 10 | Instruction bits [25:16]: rs index in [9:5], rt index in [4:0] |
| cp0_to_i | input | 1 | Decoded instruction is a coprocessor-0 move-to |
| cp0_from_i | input | 1 | Decoded instruction is a coprocessor-0 move-from |
| ex_dst_i | input | 5 | Execute-stage destination index |
| ex_wen_i | input | 1 | Execute-stage register-write enable |
| mem_dst_i | input | 5 | Memory-stage destination index |
| mem_wen_i | input | 1 | Memory-stage register-write enable |
| wb_dst_i | input | 5 | Write-back-stage destination index |
| wb_wen_i | input | 1 | Write-back-stage register-write enable |
| rf_rs_data_i | input | 32 | Register-file read data for rs |
| rf_rt_data_i | input | 32 | Register-file read data for rt |
| ex_result_i | input | 32 | Execute-stage result |
| mem_wdata_i | input | 32 | Memory-stage writeback data |
| wb_wdata_i | input | 32 | Write-back-stage data |
| cp0_rdata_i | input | 32 | Coprocessor-0 read data |
| rs_sel_o | output | 2 | rs select code |
| rt_sel_o | output | 2 | rt select code |
| rs_opnd_o | output | 32 | Selected rs operand |
| rt_opnd_o | output | 32 | Selected rt operand |

## Verification
There are no registers between the inputs and the outputs, so every select code and operand is due in the same cycle as the input pattern that causes it, with zero cycles of latency. The bench changes the inputs just after a rising edge and samples the outputs at the following falling edge. By then the combinational paths have settled, and no result depends on the order of processes at a clock edge. The assertions are immediate checks that are evaluated whenever an input changes.

// File: rtl/fwd_bypass_pkg.sv
package fwd_bypass_pkg;

    localparam int REG_IDX_W = 5;
    localparam int OPND_W    = 32;
    localparam int NUM_STG   = 3;
    localparam int SEL_W     = $clog2(NUM_STG + 1);

    // Select encoding; the order is the bypass priority (lower code wins).
    typedef enum logic [SEL_W-1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EXEC    = 2'd1,
        SRC_MEMORY  = 2'd2,
        SRC_RETIRE  = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic                 wen;
        logic [REG_IDX_W-1:0] dst;
    } wr_tag_t;

    // A producer is a candidate only when it writes a real register.
    function automatic logic tag_hits(input wr_tag_t tag,
                                      input logic [REG_IDX_W-1:0] idx);
        return tag.wen && (tag.dst == idx) && (tag.dst != '0);
    endfunction

    function automatic src_sel_e code_of_stage(input int unsigned stg);
        return src_sel_e'(stg + 1);
    endfunction

endpackage

// File: rtl/fwd_hit_detect.sv
module fwd_hit_detect
    import fwd_bypass_pkg::*;
#(
    parameter int N_STG = NUM_STG
) (
    input  logic [REG_IDX_W-1:0] src_idx_i,
    input  wr_tag_t              tags_i [N_STG],
    output logic [N_STG-1:0]     hit_o
);
    for (genvar s = 0; s < N_STG; s++) begin : g_cmp
        assign hit_o[s] = tag_hits(tags_i[s], src_idx_i);
    end
endmodule

// File: rtl/fwd_prio_sel.sv
module fwd_prio_sel
    import fwd_bypass_pkg::*;
#(
    parameter int N_STG = NUM_STG
) (
    input  logic [N_STG-1:0] hit_i,
    output src_sel_e         sel_o
);
    // Scan from the oldest stage to the youngest so the youngest hit wins.
    always_comb begin
        sel_o = SRC_REGFILE;
        for (int s = N_STG - 1; s >= 0; s--) begin
            if (hit_i[s]) begin
                sel_o = code_of_stage(unsigned'(s));
            end
        end
    end
endmodule

// File: rtl/fwd_cop0_adjust.sv
module fwd_cop0_adjust
    import fwd_bypass_pkg::*;
#(
    parameter int DATA_W = OPND_W
) (
    input  logic              to_cop_i,
    input  logic              from_cop_i,
    input  logic [DATA_W-1:0] rf_rs_i,
    input  logic [DATA_W-1:0] rf_rt_i,
    input  logic [DATA_W-1:0] cop_rdata_i,
    output logic [DATA_W-1:0] base_rs_o,
    output logic [DATA_W-1:0] base_rt_o
);
    // rs carries opcode bits on both move forms: neutralise it.
    always_comb begin
        base_rs_o = (to_cop_i || from_cop_i) ? '0 : rf_rs_i;
        base_rt_o = from_cop_i ? cop_rdata_i : rf_rt_i;
    end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_bypass_pkg::*;
#(
    parameter int DATA_W = OPND_W,
    parameter int N_STG  = NUM_STG
) (
    input  src_sel_e          sel_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] byp_i [N_STG],
    output logic [DATA_W-1:0] opnd_o
);
    always_comb begin
        opnd_o = base_i;
        for (int s = 0; s < N_STG; s++) begin
            if (sel_i == code_of_stage(unsigned'(s))) begin
                opnd_o = byp_i[s];
            end
        end
    end
endmodule

// File: rtl/fwd_decode_bypass.sv
module fwd_decode_bypass
    import fwd_bypass_pkg::*;
#(
    parameter int DATA_W = OPND_W,
    parameter int IDX_W  = REG_IDX_W
) (
    input  logic [2*IDX_W-1:0] src_fields_i,
    input  logic               cp0_to_i,
    input  logic               cp0_from_i,
    input  logic [IDX_W-1:0]   ex_dst_i,
    input  logic               ex_wen_i,
    input  logic [IDX_W-1:0]   mem_dst_i,
    input  logic               mem_wen_i,
    input  logic [IDX_W-1:0]   wb_dst_i,
    input  logic               wb_wen_i,
    input  logic [DATA_W-1:0]  rf_rs_data_i,
    input  logic [DATA_W-1:0]  rf_rt_data_i,
    input  logic [DATA_W-1:0]  ex_result_i,
    input  logic [DATA_W-1:0]  mem_wdata_i,
    input  logic [DATA_W-1:0]  wb_wdata_i,
    input  logic [DATA_W-1:0]  cp0_rdata_i,
    output logic [SEL_W-1:0]   rs_sel_o,
    output logic [SEL_W-1:0]   rt_sel_o,
    output logic [DATA_W-1:0]  rs_opnd_o,
    output logic [DATA_W-1:0]  rt_opnd_o
);
    localparam int N_OPND = 2;   // 0 = rs, 1 = rt

    wr_tag_t           tags  [NUM_STG];
    logic [DATA_W-1:0] byp   [NUM_STG];
    logic [IDX_W-1:0]  idx   [N_OPND];
    logic [DATA_W-1:0] base  [N_OPND];
    logic [DATA_W-1:0] opnd  [N_OPND];
    src_sel_e          sel   [N_OPND];

    // Stage order in the arrays equals bypass priority.
    assign tags[0] = '{wen: ex_wen_i,  dst: ex_dst_i};
    assign tags[1] = '{wen: mem_wen_i, dst: mem_dst_i};
    assign tags[2] = '{wen: wb_wen_i,  dst: wb_dst_i};
    assign byp[0]  = ex_result_i;
    assign byp[1]  = mem_wdata_i;
    assign byp[2]  = wb_wdata_i;

    assign idx[0] = src_fields_i[2*IDX_W-1:IDX_W];
    assign idx[1] = src_fields_i[IDX_W-1:0];

    fwd_cop0_adjust #(.DATA_W(DATA_W)) u_cop0 (
        .to_cop_i    (cp0_to_i),
        .from_cop_i  (cp0_from_i),
        .rf_rs_i     (rf_rs_data_i),
        .rf_rt_i     (rf_rt_data_i),
        .cop_rdata_i (cp0_rdata_i),
        .base_rs_o   (base[0]),
        .base_rt_o   (base[1])
    );

    for (genvar o = 0; o < N_OPND; o++) begin : g_opnd
        logic [NUM_STG-1:0] hit;

        fwd_hit_detect #(.N_STG(NUM_STG)) u_hit (
            .src_idx_i (idx[o]),
            .tags_i    (tags),
            .hit_o     (hit)
        );

        fwd_prio_sel #(.N_STG(NUM_STG)) u_prio (
            .hit_i (hit),
            .sel_o (sel[o])
        );

        fwd_operand_mux #(.DATA_W(DATA_W), .N_STG(NUM_STG)) u_mux (
            .sel_i  (sel[o]),
            .base_i (base[o]),
            .byp_i  (byp),
            .opnd_o (opnd[o])
        );
    end

    assign rs_sel_o  = sel[0];
    assign rt_sel_o  = sel[1];
    assign rs_opnd_o = opnd[0];
    assign rt_opnd_o = opnd[1];
endmodule

// File: rtl/fwd_decode_bypass_chk.sv
module fwd_decode_bypass_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic [2*IDX_W-1:0] src_fields_i,
    input logic               cp0_to_i,
    input logic               cp0_from_i,
    input logic [IDX_W-1:0]   ex_dst_i,
    input logic               ex_wen_i,
    input logic               mem_wen_i,
    input logic               wb_wen_i,
    input logic [DATA_W-1:0]  rf_rs_data_i,
    input logic [DATA_W-1:0]  ex_result_i,
    input logic [DATA_W-1:0]  cp0_rdata_i,
    input logic [1:0]         rs_sel_o,
    input logic [1:0]         rt_sel_o,
    input logic [DATA_W-1:0]  rs_opnd_o,
    input logic [DATA_W-1:0]  rt_opnd_o
);
    logic [IDX_W-1:0] rs_idx;
    assign rs_idx = src_fields_i[2*IDX_W-1:IDX_W];

    always_comb begin
        if (!$isunknown({src_fields_i, ex_dst_i, ex_wen_i, mem_wen_i, wb_wen_i,
                         cp0_to_i, cp0_from_i, rs_sel_o, rt_sel_o})) begin
            // R6: register 0 is never bypassed
            assert_zero_idx_R6: assert (rs_idx != '0 || rs_sel_o == 2'd0);
            // R5: no write enables, no bypass
            assert_no_wen_R5: assert ((ex_wen_i || mem_wen_i || wb_wen_i) ||
                                      (rs_sel_o == 2'd0 && rt_sel_o == 2'd0));
            // R7: execute stage outranks the others
            assert_ex_first_R7: assert (!(ex_wen_i && ex_dst_i == rs_idx && rs_idx != '0)
                                        || rs_sel_o == 2'd1);
            // R2: execute select delivers the execute result
            assert_ex_data_R2: assert (rs_sel_o != 2'd1 || rs_opnd_o == ex_result_i);
            // R9: coprocessor move zeroes an unbypassed rs
            assert_cop_rs_R9: assert (!(rs_sel_o == 2'd0 && (cp0_to_i || cp0_from_i))
                                      || rs_opnd_o == '0);
            // R10: move-from takes coprocessor data on an unbypassed rt
            assert_cop_rt_R10: assert (!(rt_sel_o == 2'd0 && cp0_from_i)
                                       || rt_opnd_o == cp0_rdata_i);
            // R1: plain instruction, no bypass, register-file data passes
            assert_rf_pass_R1: assert (!(rs_sel_o == 2'd0 && !cp0_to_i && !cp0_from_i)
                                       || rs_opnd_o == rf_rs_data_i);
        end
    end
endmodule

bind fwd_decode_bypass fwd_decode_bypass_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
    .src_fields_i (src_fields_i),
    .cp0_to_i     (cp0_to_i),
    .cp0_from_i   (cp0_from_i),
    .ex_dst_i     (ex_dst_i),
    .ex_wen_i     (ex_wen_i),
    .mem_wen_i    (mem_wen_i),
    .wb_wen_i     (wb_wen_i),
    .rf_rs_data_i (rf_rs_data_i),
    .ex_result_i  (ex_result_i),
    .cp0_rdata_i  (cp0_rdata_i),
    .rs_sel_o     (rs_sel_o),
    .rt_sel_o     (rt_sel_o),
    .rs_opnd_o    (rs_opnd_o),
    .rt_opnd_o    (rt_opnd_o)
);

// File: tb/fwd_decode_bypass_tb.sv
module fwd_decode_bypass_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [9:0]  src_fields;
    logic        cp0_to, cp0_from;
    logic [4:0]  ex_dst, mem_dst, wb_dst;
    logic        ex_wen, mem_wen, wb_wen;
    logic [31:0] rf_rs, rf_rt, ex_res, mem_wd, wb_wd, cp0_rd;
    logic [1:0]  rs_sel, rt_sel;
    logic [31:0] rs_opnd, rt_opnd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    fwd_decode_bypass dut_i (
        .src_fields_i (src_fields), .cp0_to_i (cp0_to), .cp0_from_i (cp0_from),
        .ex_dst_i (ex_dst), .ex_wen_i (ex_wen), .mem_dst_i (mem_dst), .mem_wen_i (mem_wen),
        .wb_dst_i (wb_dst), .wb_wen_i (wb_wen), .rf_rs_data_i (rf_rs), .rf_rt_data_i (rf_rt),
        .ex_result_i (ex_res), .mem_wdata_i (mem_wd), .wb_wdata_i (wb_wd),
        .cp0_rdata_i (cp0_rd), .rs_sel_o (rs_sel), .rt_sel_o (rt_sel),
        .rs_opnd_o (rs_opnd), .rt_opnd_o (rt_opnd)
    );

    // Reference model built from the requirements.
    function automatic logic [1:0] ref_sel(input logic [4:0] idx);
        if (idx != 0 && ex_wen  && ex_dst  == idx) return 2'd1;   // R2 R7
        if (idx != 0 && mem_wen && mem_dst == idx) return 2'd2;   // R3 R7
        if (idx != 0 && wb_wen  && wb_dst  == idx) return 2'd3;   // R4
        return 2'd0;                                              // R1 R5 R6
    endfunction

    function automatic logic [31:0] ref_data(input logic [1:0] s, input logic [31:0] base);
        case (s)
            2'd1:    return ex_res;
            2'd2:    return mem_wd;
            2'd3:    return wb_wd;
            default: return base;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // R12: rs in [9:5], rt in [4:0]; R8: each operand judged on its own.
    task automatic check_all(input string req);
        logic [1:0]  es_rs, es_rt;
        logic [31:0] base_rs, base_rt;
        es_rs   = ref_sel(src_fields[9:5]);
        es_rt   = ref_sel(src_fields[4:0]);
        base_rs = (cp0_to || cp0_from) ? 32'd0 : rf_rs;   // R9
        base_rt = cp0_from ? cp0_rd : rf_rt;               // R10
        chk({req, " R12 rs_sel"}, {30'd0, rs_sel}, {30'd0, es_rs});
        chk({req, " R8 rt_sel"},  {30'd0, rt_sel}, {30'd0, es_rt});
        chk({req, " R11 rs_opnd"}, rs_opnd, ref_data(es_rs, base_rs));
        chk({req, " R11 rt_opnd"}, rt_opnd, ref_data(es_rt, base_rt));
    endtask

    task automatic apply_and_check(input string req);
        @(negedge clk);
        check_all(req);
        @(posedge clk);
    endtask

    task automatic quiet();
        cp0_to = 0; cp0_from = 0;
        ex_wen = 0; mem_wen = 0; wb_wen = 0;
        ex_dst = 5'd9; mem_dst = 5'd10; wb_dst = 5'd11;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        src_fields = 10'd0;
        quiet();
        rf_rs = 32'hAAAA_0001; rf_rt = 32'hBBBB_0002; ex_res = 32'h1111_1111;
        mem_wd = 32'h2222_2222; wb_wd = 32'h3333_3333; cp0_rd = 32'hC0C0_C0C0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R1: idle state, nothing writes
        src_fields = {5'd7, 5'd8};
        apply_and_check("R1 idle");
        chk("R1 rs_sel", {30'd0, rs_sel}, 32'd0);

        // R7 R2 R3 R4: every match combination, each operand in turn
        for (int op = 0; op < 2; op++) begin
            for (int m = 0; m < 8; m++) begin
                quiet();
                src_fields = (op == 0) ? {5'd7, 5'd20} : {5'd20, 5'd7};
                ex_wen = 1; mem_wen = 1; wb_wen = 1;
                ex_dst  = m[0] ? 5'd7 : 5'd12;
                mem_dst = m[1] ? 5'd7 : 5'd13;
                wb_dst  = m[2] ? 5'd7 : 5'd14;
                apply_and_check("R7 priority");
            end
        end

        // R5: index matches but enables low
        quiet();
        src_fields = {5'd9, 5'd10};
        apply_and_check("R5 wen low");
        chk("R5 rs_opnd", rs_opnd, rf_rs);

        // R6: destination zero with enables set
        ex_dst = 0; mem_dst = 0; wb_dst = 0;
        ex_wen = 1; mem_wen = 1; wb_wen = 1;
        src_fields = {5'd0, 5'd0};
        apply_and_check("R6 zero dst");
        chk("R6 rt_sel", {30'd0, rt_sel}, 32'd0);

        // R9 R10: coprocessor moves without bypass
        quiet(); src_fields = {5'd4, 5'd6}; cp0_to = 1;
        apply_and_check("R9 move-to");
        chk("R9 rs zero", rs_opnd, 32'd0);
        chk("R10 rt unchanged on move-to", rt_opnd, rf_rt);
        quiet(); src_fields = {5'd0, 5'd6}; cp0_from = 1;
        apply_and_check("R10 move-from");
        chk("R10 rt cop data", rt_opnd, cp0_rd);

        // R11: bypass overrides coprocessor adjustments
        quiet(); src_fields = {5'd4, 5'd6}; cp0_from = 1;
        ex_wen = 1; ex_dst = 5'd4; wb_wen = 1; wb_dst = 5'd6;
        apply_and_check("R11 bypass over cop");
        chk("R11 rs ex", rs_opnd, ex_res);
        chk("R11 rt wb", rt_opnd, wb_wd);

        // Random patterns with a narrow index range to force collisions
        for (int i = 0; i < 400; i++) begin
            src_fields = {5'($urandom_range(0, 3)), 5'($urandom_range(0, 3))};
            ex_dst  = 5'($urandom_range(0, 3)); ex_wen  = 1'($urandom);
            mem_dst = 5'($urandom_range(0, 3)); mem_wen = 1'($urandom);
            wb_dst  = 5'($urandom_range(0, 3)); wb_wen  = 1'($urandom);
            cp0_to  = ($urandom_range(0, 3) == 0);
            cp0_from = ($urandom_range(0, 3) == 0);
            rf_rs = $urandom; rf_rt = $urandom; ex_res = $urandom;
            mem_wd = $urandom; wb_wd = $urandom; cp0_rd = $urandom;
            apply_and_check("R8 random");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule